// File: doc/BRIEF.md
# Burst-of-Two Dual-Port Synchronous SRAM

This block is a single-clock synchronous memory with independent read and write ports. Every access moves exactly two data beats across a port. A write request carries an entry address. The two beats that follow carry data and per-byte enables. The collector holds the first beat and merges it with the second, so the array sees one write of double width. A read request fetches one double-width entry. The block returns the low half and then the high half on consecutive cycles.

The array word is twice the port width, so the entry address is one bit narrower than a beat index would be. With the default 3-bit address the block holds 8 entries, which is 16 beats. Reads and writes may be issued in the same cycle and are coherent with each other. A write that lands while a read is fetching the same entry is forwarded byte by byte.

Back-pressure follows valid/ready on the two request channels and on the write-beat channel:
- A transfer happens on a cycle where both valid and ready are high. A valid presented while ready is low is dropped, not queued.
- `wreq_ready` falls when a write request is taken. It stays low until the cycle after the second beat has been taken.
- `rreq_ready` falls when a read request is taken. It stays low until the cycle after the last beat has been shown.
- `wbeat_ready` is high only while a write burst is collecting its beats.
- The read-beat output has no ready. The consumer must take each beat in the cycle `rbeat_valid` is high.

Top module: `burst2_sram`

## Requirements
- R1: A read request and a write request may both be taken in the same cycle, and each completes correctly and independently of the other.
- R2: The address has ADDR_W bits and selects one of 2**ADDR_W double-width entries; each address holds its own data.
- R3: After a taken write request, the first taken beat fills entry bits BEAT_W-1:0 and the second fills bits 2*BEAT_W-1:BEAT_W, and both are written in one array write on the second beat; a beat presented while `wbeat_ready` is low is ignored.
- R4: A read returns exactly two beats on consecutive cycles: the first is entry bits BEAT_W-1:0, the second entry bits 2*BEAT_W-1:BEAT_W; `rbeat_valid` is high for exactly those two cycles.
- R5: A read request taken in cycle T shows its first beat in cycle T+2 and its second in T+3, with `rbeat_valid` low in T+1.
- R6: The byte enables are sampled with each beat. Enable i covers beat bits i*BYTE_W+BYTE_W-1 : i*BYTE_W; with defaults, enable 0 covers 8:0, 1 covers 17:9, 2 covers 26:18 and 3 covers 35:27.
- R7: A byte whose enable is low in its beat keeps its previous array content in that half of the entry.
- R8: A read taken in cycle T returns the entry after every write whose second beat is taken in T+1 or earlier; a write committing in T+1 to the same address is forwarded byte by byte.
- R9: While a write burst is collecting, `wreq_ready` is low and new write requests are ignored. While a read burst is fetching or returning, `rreq_ready` is low and new read requests are ignored.
- R10: In reset and just after it, `wreq_ready` and `rreq_ready` are high, while `wbeat_ready` and `rbeat_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wreq_valid | input | 1 | Write request valid |
| wreq_ready | output | 1 | Write collector idle, request can be taken |
| wreq_addr | input | ADDR_W | Write entry address |
| wbeat_valid | input | 1 | Write beat valid |
| wbeat_ready | output | 1 | Collector is waiting for a beat |
| wbeat_data | input | BEAT_W | Write beat data |
| wbeat_be | input | BEAT_W/BYTE_W | Per-byte enables for this beat |
| rreq_valid | input | 1 | Read request valid |
| rreq_ready | output | 1 | Read sequencer idle, request can be taken |
| rreq_addr | input | ADDR_W | Read entry address |
| rbeat_valid | output | 1 | Read beat present |
| rbeat_data | output | BEAT_W | Read beat data, low half first |

## Verification
Assertions inside the modules check, on every cycle, the read timing: a taken request gives a beat two cycles later, and each burst is exactly two beats long. They also check that `rreq_ready` stays low while beats are out, that blocked write requests leave the captured address alone, that the collector is idle after each commit, and that a same-entry write during a fetch is forwarded on the lowest byte lane. Only the bench scenarios can show the byte-merged contents. These include enables held low on either beat, forwarding across whole entries, dropped requests leaving other entries untouched, and concurrent traffic to different entries.

// File: rtl/b2sram_pkg.sv
package b2sram_pkg;
  typedef enum logic [1:0] {
    WC_IDLE = 2'd0,
    WC_LO   = 2'd1,
    WC_HI   = 2'd2
  } wc_state_e;

  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,
    RS_FETCH = 2'd1,
    RS_LO    = 2'd2,
    RS_HI    = 2'd3
  } rs_state_e;
endpackage

// File: rtl/b2sram_wr_collect.sv
module b2sram_wr_collect
  import b2sram_pkg::*;
#(
  parameter int BEAT_W = 36,
  parameter int NBYTES = 4,
  parameter int ADDR_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic                  beat_valid,
  output logic                  beat_ready,
  input  logic [BEAT_W-1:0]     beat_data,
  input  logic [NBYTES-1:0]     beat_be,
  output logic                  commit,
  output logic [ADDR_W-1:0]     commit_addr,
  output logic [2*BEAT_W-1:0]   commit_data,
  output logic [2*NBYTES-1:0]   commit_mask
);
  wc_state_e           state_q, state_d;
  logic [ADDR_W-1:0]   addr_q;
  logic [BEAT_W-1:0]   lo_data_q;
  logic [NBYTES-1:0]   lo_be_q;
  logic                req_take, lo_take;

  assign req_ready  = (state_q == WC_IDLE);
  assign beat_ready = (state_q != WC_IDLE);
  assign req_take   = req_valid && req_ready;
  assign lo_take    = beat_valid && (state_q == WC_LO);
  assign commit     = beat_valid && (state_q == WC_HI);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WC_IDLE: if (req_take) state_d = WC_LO;
      WC_LO:   if (beat_valid) state_d = WC_HI;
      WC_HI:   if (beat_valid) state_d = WC_IDLE;
      default: state_d = WC_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= WC_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (req_take) addr_q <= req_addr;
    if (lo_take) begin
      lo_data_q <= beat_data;
      lo_be_q   <= beat_be;
    end
  end

  assign commit_addr = addr_q;
  assign commit_data = {beat_data, lo_data_q};
  assign commit_mask = {beat_be, lo_be_q};

  AST_WR_REQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> $stable(addr_q)); // R9
  AST_WR_IDLE_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> req_ready); // R3
  AST_WR_STRAY_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready && !req_valid) |=> req_ready); // R3
endmodule

// File: rtl/b2sram_array.sv
module b2sram_array #(
  parameter int LANE_W = 9,
  parameter int NLANES = 8,
  parameter int ADDR_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        waddr,
  input  logic [LANE_W*NLANES-1:0] wdata,
  input  logic [NLANES-1:0]        wmask,
  input  logic                     re,
  input  logic [ADDR_W-1:0]        raddr,
  output logic [LANE_W*NLANES-1:0] rdata
);
  localparam int ENTRY_W = LANE_W * NLANES;
  localparam int DEPTH   = 1 << ADDR_W;

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [ENTRY_W-1:0] fwd;
  logic [ENTRY_W-1:0] rdata_q;
  logic               same_addr;

  assign same_addr = we && (waddr == raddr);

  always_ff @(posedge clk) begin
    for (int k = 0; k < NLANES; k++) begin
      if (we && wmask[k])
        mem[waddr][k*LANE_W +: LANE_W] <= wdata[k*LANE_W +: LANE_W];
    end
  end

  always_comb begin
    fwd = mem[raddr];
    for (int k = 0; k < NLANES; k++) begin
      if (same_addr && wmask[k])
        fwd[k*LANE_W +: LANE_W] = wdata[k*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (re) rdata_q <= fwd;
  end

  assign rdata = rdata_q;

  AST_FWD_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    (re && we && (waddr == raddr) && wmask[0])
      |=> (rdata[LANE_W-1:0] == $past(wdata[LANE_W-1:0]))); // R8
endmodule

// File: rtl/b2sram_rd_seq.sv
module b2sram_rd_seq
  import b2sram_pkg::*;
#(
  parameter int BEAT_W = 36,
  parameter int ADDR_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  output logic                fetch,
  output logic [ADDR_W-1:0]   fetch_addr,
  input  logic [2*BEAT_W-1:0] entry,
  output logic                out_valid,
  output logic [BEAT_W-1:0]   out_data
);
  rs_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              req_take;

  assign req_ready = (state_q == RS_IDLE);
  assign req_take  = req_valid && req_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RS_IDLE:  if (req_take) state_d = RS_FETCH;
      RS_FETCH: state_d = RS_LO;
      RS_LO:    state_d = RS_HI;
      RS_HI:    state_d = RS_IDLE;
      default:  state_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= RS_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (req_take) addr_q <= req_addr;
  end

  assign fetch      = (state_q == RS_FETCH);
  assign fetch_addr = addr_q;
  assign out_valid  = (state_q == RS_LO) || (state_q == RS_HI);
  assign out_data   = (state_q == RS_HI) ? entry[2*BEAT_W-1:BEAT_W]
                                         : entry[BEAT_W-1:0];

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> ##2 out_valid); // R5
  AST_RD_TWO_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |=> out_valid); // R4
  AST_RD_BURST_END: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |=> !out_valid); // R4
  AST_RD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready); // R9
endmodule

// File: rtl/burst2_sram.sv
module burst2_sram #(
  parameter int BEAT_W = 36,
  parameter int BYTE_W = 9,
  parameter int ADDR_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wreq_valid,
  output logic                       wreq_ready,
  input  logic [ADDR_W-1:0]          wreq_addr,
  input  logic                       wbeat_valid,
  output logic                       wbeat_ready,
  input  logic [BEAT_W-1:0]          wbeat_data,
  input  logic [BEAT_W/BYTE_W-1:0]   wbeat_be,
  input  logic                       rreq_valid,
  output logic                       rreq_ready,
  input  logic [ADDR_W-1:0]          rreq_addr,
  output logic                       rbeat_valid,
  output logic [BEAT_W-1:0]          rbeat_data
);
  localparam int NBYTES  = BEAT_W / BYTE_W;
  localparam int ENTRY_W = 2 * BEAT_W;
  localparam int NLANES  = 2 * NBYTES;

  logic                commit;
  logic [ADDR_W-1:0]   commit_addr;
  logic [ENTRY_W-1:0]  commit_data;
  logic [NLANES-1:0]   commit_mask;
  logic                fetch;
  logic [ADDR_W-1:0]   fetch_addr;
  logic [ENTRY_W-1:0]  entry;

  b2sram_wr_collect #(
    .BEAT_W(BEAT_W), .NBYTES(NBYTES), .ADDR_W(ADDR_W)
  ) u_wr (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (wreq_valid),
    .req_ready   (wreq_ready),
    .req_addr    (wreq_addr),
    .beat_valid  (wbeat_valid),
    .beat_ready  (wbeat_ready),
    .beat_data   (wbeat_data),
    .beat_be     (wbeat_be),
    .commit      (commit),
    .commit_addr (commit_addr),
    .commit_data (commit_data),
    .commit_mask (commit_mask)
  );

  b2sram_array #(
    .LANE_W(BYTE_W), .NLANES(NLANES), .ADDR_W(ADDR_W)
  ) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (commit),
    .waddr (commit_addr),
    .wdata (commit_data),
    .wmask (commit_mask),
    .re    (fetch),
    .raddr (fetch_addr),
    .rdata (entry)
  );

  b2sram_rd_seq #(
    .BEAT_W(BEAT_W), .ADDR_W(ADDR_W)
  ) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (rreq_valid),
    .req_ready  (rreq_ready),
    .req_addr   (rreq_addr),
    .fetch      (fetch),
    .fetch_addr (fetch_addr),
    .entry      (entry),
    .out_valid  (rbeat_valid),
    .out_data   (rbeat_data)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (wreq_ready && rreq_ready && !rbeat_valid && !wbeat_ready)); // R10
endmodule

// File: tb/test_burst2_sram.sv
module test_burst2_sram;
  typedef struct packed {
    logic [2:0]  a;
    logic [35:0] d0;
    logic [3:0]  b0;
    logic [35:0] d1;
    logic [3:0]  b1;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 36'h123456789, 4'hF, 36'h9ABCDEF01, 4'hF},
    '{3'd1, 36'h111111111, 4'hF, 36'h011111110, 4'hF},
    '{3'd2, 36'h222222222, 4'hF, 36'h022222220, 4'hF},
    '{3'd3, 36'h555555555, 4'hF, 36'hAAAAAAAAA, 4'hF},
    '{3'd4, 36'h444444444, 4'hF, 36'h044444440, 4'hF},
    '{3'd5, 36'h5A5A5A5A5, 4'hF, 36'h0A5A5A5A0, 4'hF},
    '{3'd6, 36'h666666666, 4'hF, 36'h066666660, 4'hF},
    '{3'd7, 36'hFEDCBA987, 4'hF, 36'h0F0F0F0F0, 4'hF},
    '{3'd3, 36'h000000000, 4'b0101, 36'hFFFFFFFFF, 4'b1000},
    '{3'd7, 36'h333333333, 4'b0000, 36'hCCCCCCCCC, 4'b0110},
    '{3'd0, 36'h000000000, 4'b0000, 36'h000000000, 4'b0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wreq_valid = 1'b0;
  logic        wreq_ready;
  logic [2:0]  wreq_addr = '0;
  logic        wbeat_valid = 1'b0;
  logic        wbeat_ready;
  logic [35:0] wbeat_data = '0;
  logic [3:0]  wbeat_be = '0;
  logic        rreq_valid = 1'b0;
  logic        rreq_ready;
  logic [2:0]  rreq_addr = '0;
  logic        rbeat_valid;
  logic [35:0] rbeat_data;

  int checks = 0;
  int errors = 0;
  logic [71:0] model [8];
  logic [71:0] exp_a, exp_b;

  always #10 clk = ~clk;

  burst2_sram i_burst2_sram (
    .clk(clk), .rst_n(rst_n),
    .wreq_valid(wreq_valid), .wreq_ready(wreq_ready), .wreq_addr(wreq_addr),
    .wbeat_valid(wbeat_valid), .wbeat_ready(wbeat_ready),
    .wbeat_data(wbeat_data), .wbeat_be(wbeat_be),
    .rreq_valid(rreq_valid), .rreq_ready(rreq_ready), .rreq_addr(rreq_addr),
    .rbeat_valid(rbeat_valid), .rbeat_data(rbeat_data)
  );

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_write(input vec_t v);
    for (int i = 0; i < 4; i++) begin
      if (v.b0[i]) model[v.a][i*9 +: 9] = v.d0[i*9 +: 9];
      if (v.b1[i]) model[v.a][36 + i*9 +: 9] = v.d1[i*9 +: 9];
    end
  endtask

  task automatic do_write(input vec_t v);
    wreq_valid = 1'b1; wreq_addr = v.a;
    @(negedge clk);
    wreq_valid = 1'b0;
    wbeat_valid = 1'b1; wbeat_data = v.d0; wbeat_be = v.b0;
    @(negedge clk);
    wbeat_data = v.d1; wbeat_be = v.b1;
    @(negedge clk);
    wbeat_valid = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] a, input logic [71:0] exp, input string tag);
    rreq_valid = 1'b1; rreq_addr = a;
    @(negedge clk);
    rreq_valid = 1'b0;
    chk({tag, " R5 no beat at T+1"}, {71'd0, rbeat_valid}, 72'd0);
    @(negedge clk);
    chk({tag, " R5 beat0 valid at T+2"}, {71'd0, rbeat_valid}, 72'd1);
    chk({tag, " R4 beat0 low half"}, {36'd0, rbeat_data}, {36'd0, exp[35:0]});
    @(negedge clk);
    chk({tag, " R4 beat1 valid at T+3"}, {71'd0, rbeat_valid}, 72'd1);
    chk({tag, " R4 beat1 high half"}, {36'd0, rbeat_data}, {36'd0, exp[71:36]});
    @(negedge clk);
    chk({tag, " R4 burst ends"}, {70'd0, rbeat_valid, rreq_ready}, 72'd1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    // R10: state in and just after reset
    repeat (3) @(negedge clk);
    chk("R10 in reset", {68'd0, wreq_ready, rreq_ready, wbeat_ready, rbeat_valid}, 72'b1100);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after reset", {68'd0, wreq_ready, rreq_ready, wbeat_ready, rbeat_valid}, 72'b1100);

    // Vector table: R2 distinct addresses, R3 beat order, R6/R7 byte merge
    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i]);
      model_write(VEC[i]);
      do_read(VEC[i].a, model[VEC[i].a], "R2/R3/R6/R7 vector");
    end
    for (int i = 0; i < 8; i++) do_read(3'(i), model[i], "R2 readback");

    // R3: a beat with wbeat_ready low is ignored
    chk("R3 wbeat_ready idle", {71'd0, wbeat_ready}, 72'd0);
    wbeat_valid = 1'b1; wbeat_data = 36'hDEADBEEF0; wbeat_be = 4'hF;
    @(negedge clk);
    wbeat_valid = 1'b0;
    do_read(3'd4, model[4], "R3 stray beat");

    // R8: write committing during fetch is forwarded
    begin
      vec_t v;
      v = '{3'd5, 36'h0000000AB, 4'b0001, 36'hCD0000000, 4'b1000};
      model_write(v);
      exp_a = model[5];
      fork
        do_write(v);
        begin @(negedge clk); do_read(3'd5, exp_a, "R8 forward"); end
      join
      do_read(3'd5, model[5], "R8 after forward");
    end

    // R1: read and write taken in the same cycle
    begin
      vec_t v;
      v = '{3'd1, 36'h777777777, 4'hF, 36'h088888880, 4'hF};
      exp_b = model[6];
      chk("R1 both ready", {70'd0, wreq_ready, rreq_ready}, 72'b11);
      fork
        do_write(v);
        do_read(3'd6, exp_b, "R1 concurrent read");
      join
      model_write(v);
      do_read(3'd1, model[1], "R1 concurrent write");
    end

    // R9: write request while collecting is ignored
    begin
      vec_t v;
      v = '{3'd1, 36'h0000000FF, 4'b0001, 36'h000000000, 4'b0000};
      wreq_valid = 1'b1; wreq_addr = 3'd1;
      @(negedge clk);
      chk("R9 wreq_ready low while collecting", {71'd0, wreq_ready}, 72'd0);
      wreq_addr = 3'd2;
      wbeat_valid = 1'b1; wbeat_data = v.d0; wbeat_be = v.b0;
      @(negedge clk);
      wbeat_data = v.d1; wbeat_be = v.b1;
      @(negedge clk);
      wreq_valid = 1'b0; wbeat_valid = 1'b0;
      model_write(v);
      do_read(3'd2, model[2], "R9 ignored write untouched");
      do_read(3'd1, model[1], "R9 accepted write");
    end

    // R9: read request while busy is ignored
    rreq_valid = 1'b1; rreq_addr = 3'd0;
    @(negedge clk);
    chk("R9 rreq_ready low while busy", {71'd0, rreq_ready}, 72'd0);
    rreq_addr = 3'd4;
    @(negedge clk);
    chk("R9 beat0 from first address", {36'd0, rbeat_data}, {36'd0, model[0][35:0]});
    @(negedge clk);
    chk("R9 beat1 from first address", {36'd0, rbeat_data}, {36'd0, model[0][71:36]});
    rreq_valid = 1'b0;
    @(negedge clk);
    chk("R9 no third beat", {71'd0, rbeat_valid}, 72'd0);
    @(negedge clk);
    chk("R9 no second burst", {71'd0, rbeat_valid}, 72'd0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule